// File: doc/BRIEF.md
# NAND Chunk Parity Code Generator

This block watches the byte stream of a NAND data path and builds a single-error-correcting parity code over every 256-byte chunk while the bytes pass by. Each accepted byte updates a running set of line parities (one even/odd pair per bit of the byte's index within the chunk) and column parities (one even/odd pair per bit of the bit position within a byte). The stream itself is never stalled or modified. The block only generates and formats the code; syndrome decoding and data correction are handled elsewhere.

On the clock edge that accepts the last byte of a chunk, the finished code is latched into a 24-bit raw register, a one-cycle capture pulse is raised, and the accumulator restarts from zero for the next chunk. A formatted copy is presented as three bytes in the order they are stored in the spare area. Alongside it, the block gives the chunk's slot within the page and the spare-area offset where the first of those three bytes belongs. A sequencer uses the clear strobe at the start of a page and the enable input to mark which bytes are protected.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, cap_o is 0, raw_o is 0, the three code bytes are 8'hFF, slot_o is 0 and spare_off_o equals CODE_BASE (default 10).
- R2: A byte is accepted when vld_i and en_i are 1 and clr_i is 0. On the edge that accepts the 256th byte since the last capture or clear, raw_o is loaded, and cap_o is 1 for exactly the following cycle.
- R3: Line parity: raw_o[2k+1] is the XOR of all data bits of the accepted bytes whose chunk index has bit k set, and raw_o[2k] is the same over the bytes whose index has bit k clear, for k = 0..7. Index 0 is the first accepted byte.
- R4: Column parity: raw_o[17+2j] is the XOR, over all bytes of the chunk, of the data bits whose bit position has bit j set, and raw_o[16+2j] is the same over the positions with bit j clear, for j = 0..2.
- R5: raw_o[23:22] is always 0. The formatted code F = ~(raw_o << 2) masked to 24 bits is output as code_b0_o = F[23:16], code_b1_o = F[15:8] and code_b2_o = F[7:0].
- R6: While en_i is 0, bytes on the data path have no effect: they neither advance the chunk position nor change the parity.
- R7: Cycles with vld_i = 0 are skipped, so a chunk may arrive with gaps.
- R8: clr_i restarts the chunk at index 0 with zero parity and returns the slot counter to 0. It takes priority over a byte presented in the same cycle, which is dropped. It leaves raw_o, the code bytes and slot_o unchanged.
- R9: slot_o is the position within the page of the chunk whose code is latched. It counts 0, 1, ... and wraps after CHUNKS_PER_PAGE (default 2). spare_off_o = CODE_BASE + 3*slot_o, which gives 10 and 13 by default.
- R10: In every latched code, all even/odd pairs (8 line pairs and 3 column pairs) have the same XOR, which equals the parity of the whole chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Parity accumulation enable |
| clr_i | input | 1 | Clear strobe: restarts the chunk and the slot |
| vld_i | input | 1 | A data byte is present on the tap this cycle |
| data_i | input | 8 | Data byte on the tap |
| cap_o | output | 1 | One-cycle pulse: a new code has been latched |
| raw_o | output | 24 | Raw parity code of the last chunk |
| code_b0_o | output | 8 | Formatted code, first spare byte (bits 23:16) |
| code_b1_o | output | 8 | Formatted code, second spare byte (bits 15:8) |
| code_b2_o | output | 8 | Formatted code, third spare byte (bits 7:0) |
| slot_o | output | 1 | Slot within the page of the latched code |
| spare_off_o | output | 8 | Spare-area offset of code_b0_o |

## Verification
The assertions depend on a capture needing a full 256 accepted bytes. Because of this, cap_o can never be high on two neighbouring cycles, and a cycle with clr_i or with en_i low is never followed by a capture. The bench drives all inputs on the falling edge and holds them for a whole cycle. It sends the bytes disabled by en_i and the idle cycles between chunks, so they do not hide a chunk boundary. The pair-equality property holds for any data, so the random-pattern chunks and the single-bit sweep chunks both test it.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int CODE_W = 24;
  localparam int COL_W  = 6;

  // even/odd column parity pairs of one byte: [2j]=bitpos[j]==0, [2j+1]=bitpos[j]==1
  function automatic logic [COL_W-1:0] col_par(input logic [7:0] d);
    logic [COL_W-1:0] r;
    r = '0;
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < 3; j++) begin
        if (b[j]) r[2*j+1] = r[2*j+1] ^ d[b];
        else      r[2*j]   = r[2*j]   ^ d[b];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_chunk_cnt.sv
module ecc_chunk_cnt #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (take_i) cnt_q <= cnt_q + 1'b1;
  end

  assign idx_o  = cnt_q;
  assign last_o = take_i & (&cnt_q);
endmodule

// File: rtl/ecc_par_acc.sv
module ecc_par_acc
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int LINE_W = 2 * IDX_W,
  localparam int RAW_W  = LINE_W + COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clr_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [RAW_W-1:0] sum_o
);
  logic [RAW_W-1:0] acc_q;
  logic [RAW_W-1:0] contrib;
  logic             byte_par;

  assign byte_par = ^data_i;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign contrib[2*k]   = byte_par & ~idx_i[k];
    assign contrib[2*k+1] = byte_par &  idx_i[k];
  end
  assign contrib[RAW_W-1:LINE_W] = col_par(data_i);

  assign sum_o = acc_q ^ (take_i ? contrib : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (clr_i || last_i)   acc_q <= '0;
    else if (take_i)            acc_q <= sum_o;
  end
endmodule

// File: rtl/ecc_code_reg.sv
module ecc_code_reg
  import nand_ecc_pkg::*;
#(
  parameter int RAW_W           = 22,
  parameter int CHUNKS_PER_PAGE = 2,
  parameter int SPARE_W         = 8,
  parameter int CODE_BASE       = 10,
  localparam int SLOT_W = (CHUNKS_PER_PAGE > 1) ? $clog2(CHUNKS_PER_PAGE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic               clr_i,
  input  logic [RAW_W-1:0]   sum_i,
  output logic               cap_o,
  output logic [CODE_W-1:0]  raw_o,
  output logic [7:0]         code_b0_o,
  output logic [7:0]         code_b1_o,
  output logic [7:0]         code_b2_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [SPARE_W-1:0] spare_off_o
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(CHUNKS_PER_PAGE - 1);

  logic [CODE_W-1:0] raw_q;
  logic [CODE_W-1:0] fmt;
  logic [SLOT_W-1:0] nxt_q, slot_q;
  logic              cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      cap_q  <= 1'b0;
      nxt_q  <= '0;
      slot_q <= '0;
    end else begin
      cap_q <= cap_i;
      if (clr_i) nxt_q <= '0;
      else if (cap_i) begin
        raw_q  <= CODE_W'(sum_i);
        slot_q <= nxt_q;
        nxt_q  <= (nxt_q == SLOT_MAX) ? '0 : nxt_q + 1'b1;
      end
    end
  end

  assign fmt         = ~(raw_q << 2);
  assign raw_o       = raw_q;
  assign cap_o       = cap_q;
  assign code_b0_o   = fmt[23:16];
  assign code_b1_o   = fmt[15:8];
  assign code_b2_o   = fmt[7:0];
  assign slot_o      = slot_q;
  assign spare_off_o = SPARE_W'(CODE_BASE) + SPARE_W'(3) * SPARE_W'(slot_q);
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES     = 256,
  parameter int CHUNKS_PER_PAGE = 2,
  parameter int SPARE_W         = 8,
  parameter int CODE_BASE       = 10,
  localparam int IDX_W  = $clog2(CHUNK_BYTES),
  localparam int RAW_W  = 2 * IDX_W + COL_W,
  localparam int SLOT_W = (CHUNKS_PER_PAGE > 1) ? $clog2(CHUNKS_PER_PAGE) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic               vld_i,
  input  logic [7:0]         data_i,
  output logic               cap_o,
  output logic [CODE_W-1:0]  raw_o,
  output logic [7:0]         code_b0_o,
  output logic [7:0]         code_b1_o,
  output logic [7:0]         code_b2_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [SPARE_W-1:0] spare_off_o
);
  logic             take;
  logic             last;
  logic [IDX_W-1:0] idx;
  logic [RAW_W-1:0] sum;

  assign take = vld_i & en_i & ~clr_i;

  ecc_chunk_cnt #(.IDX_W(IDX_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .clr_i(clr_i),
    .idx_o(idx), .last_o(last)
  );

  ecc_par_acc #(.IDX_W(IDX_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .clr_i(clr_i),
    .last_i(last), .idx_i(idx), .data_i(data_i), .sum_o(sum)
  );

  ecc_code_reg #(
    .RAW_W(RAW_W), .CHUNKS_PER_PAGE(CHUNKS_PER_PAGE),
    .SPARE_W(SPARE_W), .CODE_BASE(CODE_BASE)
  ) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(last), .clr_i(clr_i), .sum_i(sum),
    .cap_o(cap_o), .raw_o(raw_o), .code_b0_o(code_b0_o), .code_b1_o(code_b1_o),
    .code_b2_o(code_b2_o), .slot_o(slot_o), .spare_off_o(spare_off_o)
  );
endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk #(
  parameter int CHUNK_BYTES = 256,
  localparam int IDX_W = $clog2(CHUNK_BYTES),
  localparam int NP    = IDX_W + 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        clr_i,
  input logic        cap_o,
  input logic [23:0] raw_o,
  input logic [7:0]  code_b2_o
);
  logic [NP-1:0] px;
  for (genvar i = 0; i < NP; i++) begin : g_px
    assign px[i] = raw_o[2*i] ^ raw_o[2*i+1];
  end

  AST_CAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);  // R2
  AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_o |-> $stable(raw_o));  // R2
  AST_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[23:22] == 2'b00 && code_b2_o[1:0] == 2'b11);  // R5
  AST_EN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !cap_o);  // R6
  AST_CLR_NOCAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !cap_o);  // R8
  AST_PAIR_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> ($countones(px) == 0 || $countones(px) == NP));  // R10
endmodule

bind nand_ecc_acc nand_ecc_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clr_i(clr_i),
  .cap_o(cap_o), .raw_o(raw_o), .code_b2_o(code_b2_o)
);

// File: tb/sim_nand_ecc_acc.sv
module sim_nand_ecc_acc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, clr_i = 1'b0, vld_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       cap_o;
  logic [23:0] raw_o;
  logic [7:0] code_b0_o, code_b1_o, code_b2_o;
  logic       slot_o;
  logic [7:0] spare_off_o;

  int errors = 0, checks = 0;
  logic [7:0]  mem [256];
  logic [23:0] exp_raw;
  int          exp_slot = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk_i = ~clk_i;

  nand_ecc_acc u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] ref_code();
    logic [23:0] r = '0;
    for (int i = 0; i < 256; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          for (int k = 0; k < 8; k++) r[2*k + (i >> k) % 2] ^= 1'b1;
          for (int j = 0; j < 3; j++) r[16 + 2*j + (b >> j) % 2] ^= 1'b1;
        end
    return r;
  endfunction

  task automatic drive(input logic v, input logic e, input logic c, input logic [7:0] d);
    @(negedge clk_i);
    vld_i = v; en_i = e; clr_i = c; data_i = d;
  endtask

  // mode bit0: idle gaps, bit1: disabled junk bytes
  task automatic send_chunk(input string tag, input int mode);
    logic [23:0] f;
    for (int i = 0; i < 256; i++) begin
      if ((mode & 1) && (i % 7 == 3)) drive(1'b0, 1'b1, 1'b0, 8'h5A);
      if ((mode & 2) && (i % 11 == 5)) drive(1'b1, 1'b0, 1'b0, 8'hC3);
      drive(1'b1, 1'b1, 1'b0, mem[i]);
    end
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    exp_raw = ref_code();
    f = ~(exp_raw << 2);
    chk({tag, " R2 cap"}, 32'(cap_o), 1);
    chk({tag, " R3 line"}, 32'(raw_o[15:0]), 32'(exp_raw[15:0]));
    chk({tag, " R4 col"}, 32'(raw_o[23:16]), 32'(exp_raw[23:16]));
    chk({tag, " R5 fmt"}, {8'h0, code_b0_o, code_b1_o, code_b2_o}, 32'(f));
    chk({tag, " R9 slot"}, 32'(slot_o), 32'(exp_slot));
    chk({tag, " R9 off"}, 32'(spare_off_o), 32'(10 + 3 * exp_slot));
    chk({tag, " R10 pairs"}, 32'((^exp_raw[1:0]) ^ (^exp_raw[17:16])), 0);
    exp_slot = (exp_slot + 1) % 2;
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    chk({tag, " R2 pulse"}, 32'(cap_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 cap", 32'(cap_o), 0);
    chk("R1 raw", 32'(raw_o), 0);
    chk("R1 code", {8'h0, code_b0_o, code_b1_o, code_b2_o}, 32'h00FF_FFFF);
    chk("R1 slot", 32'(slot_o), 0);
    chk("R1 off", 32'(spare_off_o), 10);
    rst_ni = 1'b1;

    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    send_chunk("zero", 0);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    send_chunk("ramp", 0);
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    send_chunk("ones", 0);

    // single-bit sweep across indices and bit positions
    for (int s = 0; s < 24; s++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[(s * 37 + 5) % 256] = 8'(1 << (s % 8));
      send_chunk("single R3 R4", 0);
    end

    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 256; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        mem[i] = lfsr[7:0];
      end
      send_chunk("gaps R7", 1);
      send_chunk("disabled R6", 2);
    end

    // clear mid-chunk; byte with clr is dropped; raw kept
    begin
      logic [23:0] held;
      held = raw_o;
      for (int i = 0; i < 100; i++) drive(1'b1, 1'b1, 1'b0, 8'h96);
      drive(1'b1, 1'b1, 1'b1, 8'h77);
      drive(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R8 raw kept", 32'(raw_o), 32'(held));
      chk("R8 no cap", 32'(cap_o), 0);
      exp_slot = 0;
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 13) ^ 8'h3C);
      send_chunk("after clr R8", 0);
    end

    // disabled bytes alone never form a chunk
    for (int i = 0; i < 300; i++) drive(1'b1, 1'b0, 1'b0, 8'(i));
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R6 no cap", 32'(cap_o), 0);
    for (int i = 0; i < 256; i++) mem[i] = 8'(255 - i);
    send_chunk("post idle R6", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule